// File: doc/BRIEF.md
# Mixed-Width Adder with Signed and Unsigned Modes

This block adds two operands whose widths may differ. The result is as wide as the wider operand. A mode input chooses how both operands are read: as two's complement numbers or as plain unsigned numbers. The narrower operand is widened to the result width before the add. In signed mode it is widened with copies of its top bit. In unsigned mode it is widened with zeros.

The main sum output wraps modulo two to the result width. The block also gives the raw carry out of the top bit. In signed mode it sets two separate flags: one for a positive result that does not fit and one for a negative result that does not fit. A result one bit wider than the sum always holds the exact value of the add. In unsigned mode that extra bit is the carry. In signed mode it is the true sign, which equals the carry out whenever the sum does not fit. The block is purely combinational.

Top module: `mixw_adder`

## Requirements
- R1: With signed_i=1, the narrower operand is sign-extended to W = max(WA, WB) bits before the add. For example, a_i=5'b01101 with b_i=4'b1011 gives sum_o=5'b01000.
- R2: With signed_i=0, the narrower operand is zero-extended. The same a_i=5'b01101 and b_i=4'b1011 give sum_o=5'b11000.
- R3: sum_o is the low W bits of the sum of the extended operands. The carry is dropped, and an overflow never changes sum_o.
- R4: In both modes, carry_o is the carry out of bit W-1 of the add of the extended bit patterns.
- R5: over_o is 1 only when signed_i=1, both extended operands are non-negative and the exact sum exceeds 2^(W-1)-1. It is detected as carry into bit W-1 = 1 with carry out = 0.
- R6: under_o is 1 only when signed_i=1, both extended operands are negative and the exact sum is below -2^(W-1). It is detected as carry into bit W-1 = 0 with carry out = 1.
- R7: over_o and under_o are both 0 when signed_i=0, and they are never 1 together.
- R8: wide_o (W+1 bits) holds the exact sum. With signed_i=0 it is {carry_o, sum_o}. With signed_i=1 it is the two's complement sum in W+1 bits, so its top bit equals carry_o whenever a flag is set. For example, 35+40 with W=7 gives wide_o=75.
- R9: Either operand may be the narrower one. When WA equals WB, neither operand is extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WA | First operand |
| b_i | input | WB | Second operand |
| signed_i | input | 1 | 1 = two's complement mode, 0 = unsigned mode |
| sum_o | output | W | Wrapped sum, W = max(WA, WB) |
| carry_o | output | 1 | Carry out of the top bit |
| over_o | output | 1 | Signed result above the positive limit |
| under_o | output | 1 | Signed result below the negative limit |
| wide_o | output | W+1 | Exact sum, one bit wider than sum_o |

## Verification
The bench builds three copies of the block. The first uses WA=5, WB=4, so the second operand is the narrower one. The second uses WA=7, WB=7, so neither operand is extended; this copy also covers the 35+40 case. The third uses WA=3, WB=6, so the first operand is the narrower one. These widths are small enough that every operand pair of every copy is applied in both modes. Each output is compared with integer arithmetic, which reaches every carry, flag and extension case, including the most negative and most positive values.

// File: rtl/mixw_pkg.sv
// Package: shared mode encoding and width helper for the mixed-width adder.
// Assumes widths are positive.
package mixw_pkg;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } mixw_mode_e;

    // Result width: the larger of the two operand widths.
    function automatic int max_width(input int wa, input int wb);
        return (wa > wb) ? wa : wb;
    endfunction

endpackage

// File: rtl/mixw_extend.sv
// Operand extender: widens an operand of WIN bits to WOUT bits.
// In signed mode the new bits copy the top bit; in unsigned mode they are zero.
// Assumes WOUT >= WIN. When the widths match, the operand passes through unchanged.
module mixw_extend #(
    parameter int WIN  = 4,
    parameter int WOUT = 5
) (
    input  logic [WIN-1:0]  opnd_i,
    input  logic            signed_i,
    output logic [WOUT-1:0] ext_o
);
    localparam int PAD = WOUT - WIN;

    generate
        if (PAD == 0) begin : g_pass
            logic unused_mode;
            // Purpose: same width, no extension needed.
            assign unused_mode = signed_i;
            assign ext_o       = opnd_i;
        end else begin : g_pad
            logic fill;
            // Purpose: choose the fill bit from the mode and the operand sign.
            assign fill  = signed_i & opnd_i[WIN-1];
            assign ext_o = {{PAD{fill}}, opnd_i};
        end
    endgenerate
endmodule

// File: rtl/mixw_ripple.sv
// Ripple-carry adder of N bits built from one full-adder cell per bit.
// It gives the carry into the top bit and the carry out of it, which the
// flag logic compares. Assumes N >= 1. The carry in is fixed at zero.
module mixw_ripple #(
    parameter int N = 5
) (
    input  logic [N-1:0] x_i,
    input  logic [N-1:0] y_i,
    output logic [N-1:0] s_o,
    output logic         cin_top_o,
    output logic         cout_o
);
    logic [N:0] chain;

    // Purpose: no carry enters the lowest bit.
    assign chain[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            // Purpose: full-adder cell for bit i.
            assign s_o[i]       = x_i[i] ^ y_i[i] ^ chain[i];
            assign chain[i + 1] = (x_i[i] & y_i[i]) | (chain[i] & (x_i[i] ^ y_i[i]));
        end
    endgenerate

    assign cin_top_o = chain[N-1];
    assign cout_o    = chain[N];
endmodule

// File: rtl/mixw_flags.sv
// Flag logic. It sorts a signed overflow by direction using the two carries
// at the top bit, and it forms the extra top bit of the wide result.
// Assumes the operand sign bits come from the extended operands.
module mixw_flags (
    input  logic signed_i,
    input  logic cin_top_i,
    input  logic cout_i,
    input  logic a_top_i,
    input  logic b_top_i,
    output logic over_o,
    output logic under_o,
    output logic wide_top_o
);
    // Purpose: the carries differ only when the signed sum does not fit;
    // the carry out tells which way it went.
    always_comb begin
        over_o  = signed_i & cin_top_i & ~cout_i;
        under_o = signed_i & ~cin_top_i & cout_i;
    end

    // Purpose: bit W of the add after one more step of sign extension,
    // or the plain carry in unsigned mode.
    always_comb begin
        if (signed_i) wide_top_o = a_top_i ^ b_top_i ^ cout_i;
        else          wide_top_o = cout_i;
    end
endmodule

// File: rtl/mixw_adder.sv
// Top: mixed-width adder with signed and unsigned modes.
// It widens both operands to W = max(WA, WB), adds them, and reports the
// wrapped sum, the carry, directional overflow flags and an exact W+1 bit sum.
// Purely combinational; assumes WA, WB >= 1.
module mixw_adder #(
    parameter int WA = 5,
    parameter int WB = 4,
    localparam int W = mixw_pkg::max_width(WA, WB)
) (
    input  logic [WA-1:0] a_i,
    input  logic [WB-1:0] b_i,
    input  logic          signed_i,
    output logic [W-1:0]  sum_o,
    output logic          carry_o,
    output logic          over_o,
    output logic          under_o,
    output logic [W:0]    wide_o
);
    logic [W-1:0] a_ext;
    logic [W-1:0] b_ext;
    logic         c_into_top;
    logic         c_out_top;
    logic         wide_top;

    mixw_extend #(.WIN(WA), .WOUT(W)) u_ext_a (
        .opnd_i   (a_i),
        .signed_i (signed_i),
        .ext_o    (a_ext)
    );

    mixw_extend #(.WIN(WB), .WOUT(W)) u_ext_b (
        .opnd_i   (b_i),
        .signed_i (signed_i),
        .ext_o    (b_ext)
    );

    mixw_ripple #(.N(W)) u_add (
        .x_i       (a_ext),
        .y_i       (b_ext),
        .s_o       (sum_o),
        .cin_top_o (c_into_top),
        .cout_o    (c_out_top)
    );

    mixw_flags u_flags (
        .signed_i   (signed_i),
        .cin_top_i  (c_into_top),
        .cout_i     (c_out_top),
        .a_top_i    (a_ext[W-1]),
        .b_top_i    (b_ext[W-1]),
        .over_o     (over_o),
        .under_o    (under_o),
        .wide_top_o (wide_top)
    );

    // Purpose: the raw carry goes out in both modes; the wide sum puts the
    // extra top bit above the wrapped sum.
    assign carry_o = c_out_top;
    assign wide_o  = {wide_top, sum_o};
endmodule

// File: rtl/mixw_adder_chk.sv
// Checker for mixw_adder. It compares the flags with the operand and sum
// signs, and the wide result with the carry. It is bound into every instance.
module mixw_adder_chk #(
    parameter int W = 5
) (
    input logic         signed_i,
    input logic         a_top,
    input logic         b_top,
    input logic [W-1:0] sum_o,
    input logic         carry_o,
    input logic         over_o,
    input logic         under_o,
    input logic [W:0]   wide_o
);
    // Purpose: immediate checks on the settled combinational outputs.
    always_comb begin
        p_flags_excl_r7: assert (!(over_o && under_o))
            else $error("over and under both set");
        p_unsigned_quiet_r7: assert (signed_i || (!over_o && !under_o))
            else $error("flag set in unsigned mode");
        p_over_signs_r5: assert (!over_o || (!a_top && !b_top && sum_o[W-1]))
            else $error("over without two non-negative operands and a negative sum");
        p_under_signs_r6: assert (!under_o || (a_top && b_top && !sum_o[W-1]))
            else $error("under without two negative operands and a non-negative sum");
        p_over_wide_r8: assert (!(over_o || under_o) || (wide_o[W] == carry_o))
            else $error("wide top bit differs from carry on overflow");
        p_unsigned_wide_r8: assert (signed_i || (wide_o[W] == carry_o))
            else $error("unsigned wide top bit differs from carry");
        p_signed_nowrap_r3: assert (!signed_i || over_o || under_o || (wide_o[W] == sum_o[W-1]))
            else $error("sum sign wrong without overflow");
    end
endmodule

bind mixw_adder mixw_adder_chk #(.W(W)) u_chk (
    .signed_i (signed_i),
    .a_top    (a_ext[W-1]),
    .b_top    (b_ext[W-1]),
    .sum_o    (sum_o),
    .carry_o  (carry_o),
    .over_o   (over_o),
    .under_o  (under_o),
    .wide_o   (wide_o)
);

// File: tb/mixw_adder_test.sv
module mixw_adder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;

    always #4 clk = ~clk;

    // Instance 1: WA=5, WB=4 (b narrower)
    logic [4:0] m_a;
    logic [3:0] m_b;
    logic       m_s;
    logic [4:0] m_sum;
    logic       m_c, m_o, m_u;
    logic [5:0] m_wide;
    mixw_adder #(.WA(5), .WB(4)) uut (
        .a_i(m_a), .b_i(m_b), .signed_i(m_s), .sum_o(m_sum),
        .carry_o(m_c), .over_o(m_o), .under_o(m_u), .wide_o(m_wide));

    // Instance 2: WA=7, WB=7 (equal widths)
    logic [6:0] e_a;
    logic [6:0] e_b;
    logic       e_s;
    logic [6:0] e_sum;
    logic       e_c, e_o, e_u;
    logic [7:0] e_wide;
    mixw_adder #(.WA(7), .WB(7)) uut_eq (
        .a_i(e_a), .b_i(e_b), .signed_i(e_s), .sum_o(e_sum),
        .carry_o(e_c), .over_o(e_o), .under_o(e_u), .wide_o(e_wide));

    // Instance 3: WA=3, WB=6 (a narrower)
    logic [2:0] n_a;
    logic [5:0] n_b;
    logic       n_s;
    logic [5:0] n_sum;
    logic       n_c, n_o, n_u;
    logic [6:0] n_wide;
    mixw_adder #(.WA(3), .WB(6)) uut_nar (
        .a_i(n_a), .b_i(n_b), .signed_i(n_s), .sum_o(n_sum),
        .carry_o(n_c), .over_o(n_o), .under_o(n_u), .wide_o(n_wide));

    // Expected values from integer arithmetic
    int x_sum, x_c, x_o, x_u, x_wide;

    function automatic int extv(int v, int n, bit sgn);
        if (sgn && ((v >> (n - 1)) & 1) == 1) return v - (1 << n);
        return v;
    endfunction

    task automatic model(int w, int wa, int wb, int a, int b, bit sgn);
        int ea, eb, tot, mask;
        ea = extv(a, wa, sgn);
        eb = extv(b, wb, sgn);
        tot = ea + eb;
        mask = (1 << w) - 1;
        x_sum  = tot & mask;
        x_wide = tot & ((1 << (w + 1)) - 1);
        x_c    = (((ea & mask) + (eb & mask)) >> w) & 1;
        x_o    = (sgn && tot > (1 << (w - 1)) - 1) ? 1 : 0;
        x_u    = (sgn && tot < -(1 << (w - 1))) ? 1 : 0;
    endtask

    task automatic cmp(string tag, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic cmp_all(string ctx, int s, int c, int o, int u, int wd);
        cmp({ctx, " R3 sum"}, s, x_sum);
        cmp({ctx, " R4 carry"}, c, x_c);
        cmp({ctx, " R5 over"}, o, x_o);
        cmp({ctx, " R6 under"}, u, x_u);
        cmp({ctx, " R8 wide"}, wd, x_wide);
    endtask

    task automatic drive_main(int a, int b, bit sgn);
        @(negedge clk);
        m_a = a[4:0]; m_b = b[3:0]; m_s = sgn;
        #2;
    endtask

    task automatic t_initial_state();
        drive_main(0, 0, 1'b0);
        cmp("R3 zero inputs sum", int'(m_sum), 0);
        cmp("R4 zero inputs carry", int'(m_c), 0);
        cmp("R7 zero inputs flags", int'({m_o, m_u}), 0);
        cmp("R8 zero inputs wide", int'(m_wide), 0);
    endtask

    task automatic t_worked_examples();
        drive_main(5'b01101, 4'b1011, 1'b1);
        cmp("R1 sign-extended example", int'(m_sum), 5'b01000);
        drive_main(5'b01101, 4'b1011, 1'b0);
        cmp("R2 zero-extended example", int'(m_sum), 5'b11000);
        drive_main(5'b01101, 4'b0101, 1'b0);
        cmp("R8 unsigned wide 13+5", int'(m_wide), 6'b010010);
        cmp("R4 unsigned carry 13+5", int'(m_c), 0);
        @(negedge clk);
        e_a = 7'd35; e_b = 7'd40; e_s = 1'b1;
        #2;
        cmp("R5 35+40 over", int'(e_o), 1);
        cmp("R3 35+40 wrapped sum", int'(e_sum), 75);
        cmp("R8 35+40 wide", int'(e_wide), 75);
        @(negedge clk);
        e_a = 7'(-35); e_b = 7'(-40); e_s = 1'b1;
        #2;
        cmp("R6 -35-40 under", int'(e_u), 1);
        cmp("R8 -35-40 wide", int'(e_wide), 256 - 75);
        cmp("R8 -35-40 wide top equals carry", int'(e_wide[7]), int'(e_c));
    endtask

    task automatic t_corners();
        drive_main(5'b01111, 4'b0111, 1'b1);
        cmp("R5 max positive pair over", int'(m_o), 1);
        drive_main(5'b10000, 4'b1000, 1'b1);
        cmp("R6 most negative pair under", int'(m_u), 1);
        cmp("R8 most negative pair wide", int'(m_wide), 64 - 24);
        drive_main(5'b10000, 4'b1000, 1'b0);
        cmp("R7 unsigned no flags", int'({m_o, m_u}), 0);
        cmp("R4 unsigned carry 16+8", int'(m_c), 0);
        drive_main(5'b11111, 4'b0001, 1'b1);
        cmp("R7 -1+1 no flags", int'({m_o, m_u}), 0);
        cmp("R4 -1+1 raw carry", int'(m_c), 1);
        cmp("R8 -1+1 wide zero", int'(m_wide), 0);
    endtask

    task automatic t_sweep_main();
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 32; a++)
                for (int b = 0; b < 16; b++) begin
                    drive_main(a, b, s[0]);
                    model(5, 5, 4, a, b, s[0]);
                    cmp_all(s[0] ? "R1 main" : "R2 main", int'(m_sum), int'(m_c),
                            int'(m_o), int'(m_u), int'(m_wide));
                end
    endtask

    task automatic t_sweep_equal();
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 128; a++)
                for (int b = 0; b < 128; b++) begin
                    @(negedge clk);
                    e_a = a[6:0]; e_b = b[6:0]; e_s = s[0];
                    #2;
                    model(7, 7, 7, a, b, s[0]);
                    cmp_all("R9 equal", int'(e_sum), int'(e_c), int'(e_o),
                            int'(e_u), int'(e_wide));
                end
    endtask

    task automatic t_sweep_narrow_a();
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 64; b++) begin
                    @(negedge clk);
                    n_a = a[2:0]; n_b = b[5:0]; n_s = s[0];
                    #2;
                    model(6, 3, 6, a, b, s[0]);
                    cmp_all("R9 a-narrow", int'(n_sum), int'(n_c), int'(n_o),
                            int'(n_u), int'(n_wide));
                end
    endtask

    initial begin
        m_a = '0; m_b = '0; m_s = 1'b0;
        e_a = '0; e_b = '0; e_s = 1'b0;
        n_a = '0; n_b = '0; n_s = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_initial_state();
        t_worked_examples();
        t_corners();
        t_sweep_main();
        t_sweep_equal();
        t_sweep_narrow_a();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule